// File: doc/BRIEF.md
# Transposed-RAM Binary Match Table

This block is a binary content-addressable table of 32 entries, each holding an 8-bit key. There are no per-entry comparators. The storage is a single 8192-bit bit matrix with two views. The write side addresses one bit at a time with a 13-bit address, `{key, entry}`. The search side reads a whole 32-bit row, using the 8-bit search key as the row address. Bit `i` of row `K` is set exactly when entry `i` currently holds key `K`. One read of the row therefore returns the match vector for every entry at once, and several entries may hold the same key.

A controller state machine runs the block. Its states are:

- `ST_CLEAR`: after reset, it zeroes all 256 rows, one row per cycle, and holds `ready` low.
- `ST_IDLE`: it accepts store and erase requests.
- `ST_DROP`: it clears the bit for the entry's previously stored key, using a per-entry shadow register of key and valid flag.
- `ST_SET`: it sets the bit for the new key.

The transitions are:

- `ST_CLEAR` goes to `ST_IDLE` once row 255 has been cleared.
- `ST_IDLE` goes to `ST_DROP` on an erase, or on a store to an occupied entry.
- `ST_IDLE` goes to `ST_SET` on a store to an empty entry.
- `ST_DROP` goes to `ST_SET` on a store, or to `ST_IDLE` on an erase.
- `ST_SET` always goes to `ST_IDLE`.

Searches are accepted in any cycle once `ready` is high, including while a write is in progress. A search has one cycle of latency.

Top module: `ram_cam`

## Requirements
- R1: While reset is held, and after its release, `ready` and `srch_valid` are low. `ready` rises exactly 256 clock edges after reset is released and then stays high.
- R2: Search and write requests presented while `ready` is low are ignored. No `srch_valid` pulse results, and nothing is stored.
- R3: After key K is stored in entry i, a search for K returns bit i set in `srch_hits`.
- R4: All entries that hold the searched key are reported together in the same `srch_hits` word. Bit i of the word corresponds to entry i.
- R5: `srch_any` is high exactly when `srch_hits` is nonzero. A key held by no entry returns an all-zero vector.
- R6: Storing a new key in an occupied entry removes the old key, so a later search for the old key no longer reports that entry.
- R7: Erasing an entry removes it from every search result. Erasing an empty entry changes no search result.
- R8: A search accepted at a clock edge gives `srch_valid` high for exactly the following cycle, with that key's result.
- R9: `busy` stays high for 1 cycle after an accepted store to an empty entry or an accepted erase, and for 2 cycles after an accepted store to an occupied entry. Write requests made while `busy` is high are ignored.
- R10: A search accepted at the same edge that commits a write returns the contents from before that write. The new entry shows up from the next search on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write request, taken when ready and not busy |
| wr_erase | input | 1 | 1 = erase the entry, 0 = store `wr_key` in it |
| wr_entry | input | 5 | Target entry index |
| wr_key | input | 8 | Key to store |
| busy | output | 1 | A write is in progress |
| ready | output | 1 | Post-reset clear has finished |
| srch_req | input | 1 | Search request |
| srch_key | input | 8 | Search key |
| srch_valid | output | 1 | Search result valid this cycle |
| srch_hits | output | 32 | One bit per matching entry |
| srch_any | output | 1 | At least one entry matched |

## Verification
The hardest situation to reach is a search that lands on the very edge where the bit-matrix write commits. Reaching it needs a store to an entry known to be empty, and a search request raised exactly one cycle after the write is accepted. The bench first erases the entry, which makes the write a single `ST_SET` cycle, and then issues the search in that cycle. It expects the old row, and expects the new one on the next search. Random traffic confined to a few keys creates crowded rows, where overwrites and erases must remove exactly one bit among several.

// File: rtl/ram_cam_pkg.sv
package ram_cam_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_DROP,
        ST_SET
    } cam_state_t;
endpackage

// File: rtl/cam_bitmatrix.sv
module cam_bitmatrix #(
    parameter int KEY_W   = 8,
    parameter int DEPTH   = 32,
    parameter int ENTRY_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     row_clr,
    input  logic [KEY_W-1:0]         row_clr_idx,
    input  logic                     bit_we,
    input  logic [KEY_W+ENTRY_W-1:0] bit_addr,
    input  logic                     bit_val,
    input  logic                     rd_en,
    input  logic [KEY_W-1:0]         rd_key,
    output logic [DEPTH-1:0]         rd_row
);
    localparam int ROWS = 2 ** KEY_W;

    logic [DEPTH-1:0] mem [ROWS];

    // write view: one bit per {key, entry}; clear view: a whole row
    always_ff @(posedge clk) begin
        if (row_clr) begin
            mem[row_clr_idx] <= '0;
        end else if (bit_we) begin
            mem[bit_addr[KEY_W+ENTRY_W-1:ENTRY_W]][bit_addr[ENTRY_W-1:0]] <= bit_val;
        end
    end

    // read view: the key selects a row, the row is the match vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_row <= '0;
        end else if (rd_en) begin
            rd_row <= mem[rd_key];
        end
    end
endmodule

// File: rtl/cam_shadow.sv
module cam_shadow #(
    parameter int KEY_W   = 8,
    parameter int DEPTH   = 32,
    parameter int ENTRY_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] idx,
    input  logic               drop_en,
    input  logic               set_en,
    input  logic [KEY_W-1:0]   key_in,
    output logic [KEY_W-1:0]   cur_key,
    output logic               cur_valid
);
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] val_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_q[g] <= '0;
                val_q[g] <= 1'b0;
            end else if (idx == ENTRY_W'(g)) begin
                if (set_en) begin
                    key_q[g] <= key_in;
                    val_q[g] <= 1'b1;
                end else if (drop_en) begin
                    val_q[g] <= 1'b0;
                end
            end
        end
    end

    assign cur_key   = key_q[idx];
    assign cur_valid = val_q[idx];

    // R6
    shadow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (key_q[$past(idx)] == $past(key_in)) && val_q[$past(idx)]);
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
    import ram_cam_pkg::*;
#(
    parameter int KEY_W   = 8,
    parameter int ENTRY_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_req,
    input  logic                     wr_erase,
    input  logic [ENTRY_W-1:0]       wr_entry,
    input  logic [KEY_W-1:0]         wr_key,
    input  logic [KEY_W-1:0]         sh_key,
    input  logic                     sh_valid,
    output logic [ENTRY_W-1:0]       sh_idx,
    output logic                     sh_drop,
    output logic                     sh_set,
    output logic [KEY_W-1:0]         sh_key_in,
    output logic                     row_clr,
    output logic [KEY_W-1:0]         row_clr_idx,
    output logic                     bit_we,
    output logic [KEY_W+ENTRY_W-1:0] bit_addr,
    output logic                     bit_val,
    output logic                     ready,
    output logic                     busy
);
    cam_state_t         state_q, state_d;
    logic               op_erase_q;
    logic [ENTRY_W-1:0] op_entry_q;
    logic [KEY_W-1:0]   op_key_q;
    logic [KEY_W-1:0]   clr_cnt_q;
    logic               accept;

    assign accept = (state_q == ST_IDLE) && wr_req;

    // state register and operation latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_CLEAR;
            op_erase_q <= 1'b0;
            op_entry_q <= '0;
            op_key_q   <= '0;
            clr_cnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                clr_cnt_q <= clr_cnt_q + 1'b1;
            end
            if (accept) begin
                op_erase_q <= wr_erase;
                op_entry_q <= wr_entry;
                op_key_q   <= wr_key;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        sh_idx      = op_entry_q;
        sh_drop     = 1'b0;
        sh_set      = 1'b0;
        sh_key_in   = op_key_q;
        row_clr     = 1'b0;
        row_clr_idx = clr_cnt_q;
        bit_we      = 1'b0;
        bit_addr    = {op_key_q, op_entry_q};
        bit_val     = 1'b0;
        ready       = 1'b1;
        busy        = 1'b1;
        unique case (state_q)
            ST_CLEAR: begin
                ready   = 1'b0;
                row_clr = 1'b1;
                if (clr_cnt_q == '1) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                busy   = 1'b0;
                sh_idx = wr_entry;
                if (wr_req) begin
                    state_d = (wr_erase || sh_valid) ? ST_DROP : ST_SET;
                end
            end
            ST_DROP: begin
                bit_we   = sh_valid;
                bit_addr = {sh_key, op_entry_q};
                bit_val  = 1'b0;
                sh_drop  = 1'b1;
                state_d  = op_erase_q ? ST_IDLE : ST_SET;
            end
            ST_SET: begin
                bit_we  = 1'b1;
                bit_val = 1'b1;
                sh_set  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    // R9
    set_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SET) |=> (state_q == ST_IDLE));

    // R9
    drop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |=> (state_q != ST_DROP));

    // R1
    ready_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/ram_cam.sv
module ram_cam #(
    parameter int KEY_W   = 8,
    parameter int DEPTH   = 32,
    parameter int ENTRY_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic               wr_erase,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic [KEY_W-1:0]   wr_key,
    output logic               busy,
    output logic               ready,
    input  logic               srch_req,
    input  logic [KEY_W-1:0]   srch_key,
    output logic               srch_valid,
    output logic [DEPTH-1:0]   srch_hits,
    output logic               srch_any
);
    localparam int ADDR_W = KEY_W + ENTRY_W;

    logic [KEY_W-1:0]   sh_key, sh_key_in, row_clr_idx;
    logic               sh_valid, sh_drop, sh_set;
    logic [ENTRY_W-1:0] sh_idx;
    logic               row_clr, bit_we, bit_val;
    logic [ADDR_W-1:0]  bit_addr;
    logic               srch_acc;

    assign srch_acc = srch_req && ready;

    cam_ctrl #(.KEY_W(KEY_W), .ENTRY_W(ENTRY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_erase(wr_erase), .wr_entry(wr_entry), .wr_key(wr_key),
        .sh_key(sh_key), .sh_valid(sh_valid), .sh_idx(sh_idx),
        .sh_drop(sh_drop), .sh_set(sh_set), .sh_key_in(sh_key_in),
        .row_clr(row_clr), .row_clr_idx(row_clr_idx),
        .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
        .ready(ready), .busy(busy)
    );

    cam_shadow #(.KEY_W(KEY_W), .DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .idx(sh_idx),
        .drop_en(sh_drop), .set_en(sh_set), .key_in(sh_key_in),
        .cur_key(sh_key), .cur_valid(sh_valid)
    );

    cam_bitmatrix #(.KEY_W(KEY_W), .DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_matrix (
        .clk(clk), .rst_n(rst_n),
        .row_clr(row_clr), .row_clr_idx(row_clr_idx),
        .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
        .rd_en(srch_acc), .rd_key(srch_key), .rd_row(srch_hits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srch_valid <= 1'b0;
        end else begin
            srch_valid <= srch_acc;
        end
    end

    assign srch_any = |srch_hits;

    // R8
    srch_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && ready) |=> srch_valid);

    // R2
    no_srch_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !srch_valid);
endmodule

// File: tb/ram_cam_tb.sv
`timescale 1ns/1ps
module ram_cam_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0, wr_erase = 1'b0;
    logic [4:0]  wr_entry = '0;
    logic [7:0]  wr_key = '0;
    logic        busy, ready;
    logic        srch_req = 1'b0;
    logic [7:0]  srch_key = '0;
    logic        srch_valid, srch_any;
    logic [31:0] srch_hits;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] m_key [32];
    bit         m_val [32];

    always #2.5 clk = ~clk;

    ram_cam u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_erase(wr_erase), .wr_entry(wr_entry), .wr_key(wr_key),
        .busy(busy), .ready(ready),
        .srch_req(srch_req), .srch_key(srch_key),
        .srch_valid(srch_valid), .srch_hits(srch_hits), .srch_any(srch_any)
    );

    function automatic logic [31:0] exp_hits(logic [7:0] k);
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++) if (m_val[i] && m_key[i] == k) v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(bit er, logic [4:0] e, logic [7:0] k);
        int n = 0;
        int want = er ? 1 : (m_val[e] ? 2 : 1);
        wr_req = 1'b1; wr_erase = er; wr_entry = e; wr_key = k;
        step();
        wr_req = 1'b0;
        while (busy && n < 10) begin n++; step(); end
        chk(n == want, "R9 busy length", n, want);
        if (er) m_val[e] = 1'b0;
        else begin m_val[e] = 1'b1; m_key[e] = k; end
    endtask

    task automatic do_search(logic [7:0] k, string req);
        logic [31:0] e = exp_hits(k);
        srch_req = 1'b1; srch_key = k;
        step();
        srch_req = 1'b0;
        chk(srch_valid == 1'b1, "R8 valid", srch_valid, 1);
        chk(srch_hits == e, req, srch_hits, e);
        chk(srch_any == (e != 0), "R5 any flag", srch_any, (e != 0));
        step();
        chk(srch_valid == 1'b0, "R8 single pulse", srch_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] old;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) begin m_val[i] = 1'b0; m_key[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!ready && !srch_valid, "R1 reset state", {ready, srch_valid}, 0);
        rst_n = 1'b1;
        // R2: requests during clear are ignored
        wr_req = 1'b1; wr_erase = 1'b0; wr_entry = 5'd1; wr_key = 8'h3c;
        srch_req = 1'b1; srch_key = 8'h3c;
        n = 0;
        while (!ready && n < 400) begin
            step(); n++;
            if (!ready) chk(!srch_valid, "R2 no result before ready", srch_valid, 0);
        end
        wr_req = 1'b0; srch_req = 1'b0;
        chk(n == 256, "R1 ready timing", n, 256);
        step();
        chk(ready == 1'b1, "R1 ready held", ready, 1);
        do_search(8'h3c, "R2 write during clear ignored");
        do_search(8'h00, "R5 empty table");

        // R3 basic store
        do_write(1'b0, 5'd0, 8'hA5);
        do_search(8'hA5, "R3 single entry");
        // R4 multi match including edge entries
        do_write(1'b0, 5'd31, 8'hA5);
        do_write(1'b0, 5'd7, 8'hA5);
        do_search(8'hA5, "R4 multi match");
        do_search(8'hFF, "R5 no match");
        // R6 overwrite
        do_write(1'b0, 5'd7, 8'h12);
        do_search(8'hA5, "R6 old key removed");
        do_search(8'h12, "R6 new key present");
        // R7 erase and erase of empty
        do_write(1'b1, 5'd0, 8'h00);
        do_search(8'hA5, "R7 erased entry gone");
        do_write(1'b1, 5'd20, 8'h00);
        do_search(8'h00, "R7 empty erase harmless");
        do_search(8'hA5, "R7 empty erase harmless");

        // R9 request during busy ignored
        wr_req = 1'b1; wr_erase = 1'b0; wr_entry = 5'd31; wr_key = 8'h40;
        step();
        wr_entry = 5'd4; wr_key = 8'h66;
        chk(busy == 1'b1, "R9 busy asserted", busy, 1);
        step();
        wr_req = 1'b0;
        while (busy) step();
        m_key[31] = 8'h40;
        do_search(8'h66, "R9 write while busy ignored");
        do_search(8'h40, "R9 first write kept");

        // R10 read-before-write on the commit edge
        do_write(1'b1, 5'd9, 8'h00);
        old = exp_hits(8'h40);
        wr_req = 1'b1; wr_erase = 1'b0; wr_entry = 5'd9; wr_key = 8'h40;
        step();
        wr_req = 1'b0;
        srch_req = 1'b1; srch_key = 8'h40;
        step();
        srch_req = 1'b0;
        chk(srch_valid && srch_hits == old, "R10 old contents", srch_hits, old);
        m_val[9] = 1'b1; m_key[9] = 8'h40;
        step();
        do_search(8'h40, "R10 new entry next search");

        // random traffic on few keys
        for (int it = 0; it < 400; it++) begin
            logic [7:0] k = 8'($urandom_range(0, 5)) | 8'h80;
            logic [4:0] e = 5'($urandom_range(0, 31));
            int r = $urandom_range(0, 9);
            if (r < 4) do_write(1'b0, e, k);
            else if (r < 6) do_write(1'b1, e, 8'h00);
            else do_search(k, "R4 random search");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule